// File: doc/BRIEF.md
# Keyed Low-Speed Clock Selector

This block produces the slow timekeeping tick for a real-time-clock peripheral. It has two sources, both modelled as single-cycle tick enables in the system clock domain. The first is a fast internal RC oscillator, nominally around 667 kHz, which passes through a programmable divider. The second is an external 32 kHz crystal, which is forwarded without division. A gated copy of the selected tick is also driven out for use outside the peripheral.

Three registers configure the block through a simple write-strobe and address port, with combinational read-back:
- The source-select register at offset 0x00 is protected. A write changes it only when the upper half of the written word carries the unlock key.
- The divider register at offset 0x08 needs no key.
- The output-gate register at offset 0x60 needs no key.

The source choice is held in a two-state machine with these states and transitions:
- State `SRC_INT_DIV` is the divided internal oscillator. It is entered at reset, and through transition T_SEL_INT, which is a keyed write with bit 0 = 0.
- State `SRC_EXT_XTAL` is the external crystal. It is entered through transition T_SEL_EXT, which is a keyed write with bit 0 = 1.

A write without the key leaves the state machine where it is.

Top module: `lsc_clk_select`

## Requirements
- R1: After reset the source is the internal oscillator, the divider value is 0 and the output gate is off, so reads of offsets 0x00, 0x08 and 0x60 all return 0.
- R2: A write to offset 0x00 whose bits [31:16] equal 0x16AA loads bit 0 as the source select: 1 selects the external crystal, 0 selects the internal oscillator. The new selection is effective from the next cycle.
- R3: A write to offset 0x00 whose bits [31:16] differ from 0x16AA has no effect. Both the read-back value and the tick source stay unchanged.
- R4: A read of offset 0x00 returns the source select in bit 0 and zero in every other bit. The key is never stored.
- R5: With the internal source selected and divider value N, `slow_tick` pulses together with every (N+1)-th `int_osc_tick`. The first pulse after a restart comes on the (N+1)-th tick.
- R6: With the external source selected, `slow_tick` equals `ext_xtal_tick` in every cycle, and `int_osc_tick` has no effect on it.
- R7: Bit 0 of offset 0x60 gates the output. When it is 1, `slow_tick_out` equals `slow_tick`. When it is 0, `slow_tick_out` is 0.
- R8: A write that changes the divider value or the source selection restarts the internal count from zero. Counting then resumes under the new settings with no short interval.
- R9: A write to offset 0x08 needs no key and keeps only bits [4:0]. A read of offset 0x08 returns that value with zero above it. Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| int_osc_tick | input | 1 | Tick enable from the internal RC oscillator |
| ext_xtal_tick | input | 1 | Tick enable from the external crystal |
| slow_tick | output | 1 | Selected slow timekeeping tick |
| slow_tick_out | output | 1 | Gated copy of `slow_tick` |

## Verification
A state machine left in the wrong state would show up in the very next cycle, in two places: bit 0 of the source-select read-back, and `slow_tick` following the wrong input. A divider count that drifts or fails to restart shows no symptom until the next expected pulse. It would then appear as a `slow_tick` pulse that comes early, comes late or is missing, at most N+1 internal ticks later. Because of this, the bench compares every output in every cycle against a behavioural model, across several divider values and a change of divider value in mid-count.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

    typedef enum logic {
        SRC_INT_DIV  = 1'b0,
        SRC_EXT_XTAL = 1'b1
    } src_e;

    localparam logic [15:0] UNLOCK_KEY = 16'h16AA;

    localparam logic [7:0] OFF_SRC_SEL = 8'h00;
    localparam logic [7:0] OFF_DIVIDER = 8'h08;
    localparam logic [7:0] OFF_OUTGATE = 8'h60;

endpackage

// File: rtl/lsc_regs.sv
module lsc_regs
    import lsc_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32,
    parameter int PRESC_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output src_e               src,
    output logic [PRESC_W-1:0] presc,
    output logic               gate,
    output logic               restart,
    output logic [DATA_W-1:0]  rdata
);

    localparam int KEY_MSB = DATA_W - 1;

    src_e               src_nx;
    logic               hit_sel;
    logic               hit_div;
    logic               hit_gate;
    logic               key_ok;
    logic               sel_wr;
    logic [PRESC_W-1:0] presc_nx;

    always_comb begin
        hit_sel  = (addr == ADDR_W'(OFF_SRC_SEL));
        hit_div  = (addr == ADDR_W'(OFF_DIVIDER));
        hit_gate = (addr == ADDR_W'(OFF_OUTGATE));
        key_ok   = (wdata[KEY_MSB -: 16] == UNLOCK_KEY);
        sel_wr   = wr && hit_sel && key_ok;
    end

    // Source state machine: next-state logic
    always_comb begin
        src_nx = src;
        unique case (src)
            SRC_INT_DIV:  if (sel_wr && wdata[0])  src_nx = SRC_EXT_XTAL; // T_SEL_EXT
            SRC_EXT_XTAL: if (sel_wr && !wdata[0]) src_nx = SRC_INT_DIV;  // T_SEL_INT
        endcase
    end

    always_comb begin
        presc_nx = (wr && hit_div) ? wdata[PRESC_W-1:0] : presc;
        restart  = (src_nx != src) || (presc_nx != presc);
    end

    // Source state machine: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src   <= SRC_INT_DIV;
            presc <= '0;
            gate  <= 1'b0;
        end else begin
            src   <= src_nx;
            presc <= presc_nx;
            if (wr && hit_gate) gate <= wdata[0];
        end
    end

    // Read-back path
    always_comb begin
        rdata = '0;
        if (hit_sel)       rdata[0]         = (src == SRC_EXT_XTAL);
        else if (hit_div)  rdata[PRESC_W-1:0] = presc;
        else if (hit_gate) rdata[0]         = gate;
    end

    a_r2_keyed_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && hit_sel && key_ok) |=> (src == src_e'($past(wdata[0]))));

    a_r3_badkey_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && hit_sel && !key_ok) |=> $stable(src));

    a_r9_div_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && hit_div) |=> (presc == $past(wdata[PRESC_W-1:0])));

endmodule

// File: rtl/lsc_div.sv
module lsc_div
    import lsc_pkg::*;
#(
    parameter int PRESC_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  src_e               src,
    input  logic [PRESC_W-1:0] presc,
    input  logic               restart,
    input  logic               int_tick,
    input  logic               ext_tick,
    output logic               slow_tick
);

    logic [PRESC_W-1:0] cnt;
    logic               wrap;

    always_comb begin
        wrap = (cnt == presc);
        unique case (src)
            SRC_INT_DIV:  slow_tick = int_tick && wrap;
            SRC_EXT_XTAL: slow_tick = ext_tick;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= '0;
        end else if (src == SRC_INT_DIV && int_tick) begin
            cnt <= wrap ? '0 : cnt + 1'b1;
        end
    end

    a_r8_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt == '0));

    a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= presc);

    a_r5_no_double: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && src == SRC_INT_DIV && presc != '0 && slow_tick) |=> !slow_tick);

endmodule

// File: rtl/lsc_outgate.sv
module lsc_outgate (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic tick_in,
    output logic tick_out
);

    always_comb tick_out = en && tick_in;

    a_r7_gate_pass: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (tick_out == tick_in));

endmodule

// File: rtl/lsc_clk_select.sv
module lsc_clk_select
    import lsc_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32,
    parameter int PRESC_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              int_osc_tick,
    input  logic              ext_xtal_tick,
    output logic              slow_tick,
    output logic              slow_tick_out
);

    src_e               src;
    logic [PRESC_W-1:0] presc;
    logic               gate;
    logic               restart;

    lsc_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRESC_W(PRESC_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .src     (src),
        .presc   (presc),
        .gate    (gate),
        .restart (restart),
        .rdata   (reg_rdata)
    );

    lsc_div #(.PRESC_W(PRESC_W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .src       (src),
        .presc     (presc),
        .restart   (restart),
        .int_tick  (int_osc_tick),
        .ext_tick  (ext_xtal_tick),
        .slow_tick (slow_tick)
    );

    lsc_outgate u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (gate),
        .tick_in  (slow_tick),
        .tick_out (slow_tick_out)
    );

endmodule

// File: tb/sim_lsc_clk_select.sv
module sim_lsc_clk_select;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        int_osc_tick = 1'b0;
    logic        ext_xtal_tick = 1'b0;
    logic        slow_tick;
    logic        slow_tick_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // behavioural reference state
    int m_sel   = 0;
    int m_presc = 0;
    int m_gate  = 0;
    int m_cnt   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lsc_clk_select u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_wr        (reg_wr),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .int_osc_tick  (int_osc_tick),
        .ext_xtal_tick (ext_xtal_tick),
        .slow_tick     (slow_tick),
        .slow_tick_out (slow_tick_out)
    );

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [7:0] a);
        if (a == 8'h00) return 32'(m_sel);
        if (a == 8'h08) return 32'(m_presc);
        if (a == 8'h60) return 32'(m_gate);
        return 32'h0;
    endfunction

    task automatic step(input logic w, input logic [7:0] a, input logic [31:0] d,
                        input logic it, input logic et, input string tag);
        logic exp_tick;
        int   new_sel;
        int   new_p;
        @(negedge clk);
        reg_wr = w; reg_addr = a; reg_wdata = d;
        int_osc_tick = it; ext_xtal_tick = et;
        #1;
        exp_tick = (m_sel == 1) ? et : (it && (m_cnt == m_presc));
        check(tag, "slow_tick", 32'(slow_tick), 32'(exp_tick));
        check("R7", "slow_tick_out", 32'(slow_tick_out), 32'(exp_tick && (m_gate == 1)));
        check(tag, "reg_rdata", reg_rdata, model_read(a));
        @(posedge clk);
        new_sel = m_sel;
        new_p   = m_presc;
        if (w && a == 8'h00 && d[31:16] == 16'h16AA) new_sel = int'(d[0]);
        if (w && a == 8'h08) new_p = int'(d[4:0]);
        if (w && a == 8'h60) m_gate = int'(d[0]);
        if (new_sel != m_sel || new_p != m_presc) m_cnt = 0;
        else if (m_sel == 0 && it) m_cnt = (m_cnt == m_presc) ? 0 : m_cnt + 1;
        m_sel = new_sel;
        m_presc = new_p;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state seen through every register
        step(0, 8'h00, 0, 0, 0, "R1");
        step(0, 8'h08, 0, 0, 0, "R1");
        step(0, 8'h60, 0, 0, 0, "R1");

        // R5: divide by one after reset
        for (int i = 0; i < 8; i++) step(0, 8'h44, 0, 1, 0, "R5");

        // R9: prescaler write without key, upper bits dropped, unmapped read zero
        step(1, 8'h08, 32'hFFFF_FFE3, 0, 0, "R9");
        step(0, 8'h08, 0, 0, 0, "R9");
        step(0, 8'h24, 0, 0, 0, "R9");

        // R5: divide by four with irregular internal ticks
        for (int i = 0; i < 24; i++) step(0, 8'h08, 0, (i % 3) != 0, 1, "R5");

        // R3: wrong key ignored, internal source still used
        step(1, 8'h00, 32'h16AB_0001, 1, 1, "R3");
        step(1, 8'h00, 32'h0000_0001, 1, 1, "R3");
        for (int i = 0; i < 8; i++) step(0, 8'h00, 0, 1, (i % 2) == 0, "R3");

        // R2 / R4: keyed switch to the crystal, key not read back
        step(1, 8'h00, 32'h16AA_FFFF, 1, 0, "R2");
        step(0, 8'h00, 0, 0, 0, "R4");

        // R6: crystal ticks pass straight through
        for (int i = 0; i < 16; i++) step(0, 8'h00, 0, (i % 2) == 1, (i % 5) == 1 || (i % 7) == 3, "R6");

        // R7: output gate on, then off
        step(1, 8'h60, 32'h0000_0001, 0, 1, "R7");
        for (int i = 0; i < 8; i++) step(0, 8'h60, 0, 0, (i % 3) == 0, "R7");
        step(1, 8'h60, 32'h0000_0000, 0, 1, "R7");
        for (int i = 0; i < 6; i++) step(0, 8'h60, 0, 0, 1, "R7");
        step(1, 8'h60, 32'h0000_0001, 0, 0, "R7");

        // R2 / R8: keyed switch back restarts count
        step(1, 8'h00, 32'h16AA_0000, 1, 1, "R2");
        for (int i = 0; i < 10; i++) step(0, 8'h00, 0, 1, 0, "R8");

        // R8: prescaler change in mid-count
        step(1, 8'h08, 32'h0000_0004, 1, 0, "R8");
        step(0, 8'h08, 0, 1, 0, "R8");
        step(0, 8'h08, 0, 1, 0, "R8");
        step(1, 8'h08, 32'h0000_0002, 1, 0, "R8");
        for (int i = 0; i < 12; i++) step(0, 8'h08, 0, 1, 0, "R8");

        // R8: rewriting same prescaler value does not restart
        step(0, 8'h08, 0, 1, 0, "R8");
        step(1, 8'h08, 32'h0000_0002, 1, 0, "R8");
        for (int i = 0; i < 6; i++) step(0, 8'h08, 0, 1, 0, "R8");

        // R5: largest divider value
        step(1, 8'h08, 32'h0000_001F, 0, 0, "R5");
        for (int i = 0; i < 70; i++) step(0, 8'h08, 0, 1, 0, "R5");

        finish_run();
    end

endmodule